// File: doc/BRIEF.md
# Dual-Channel Display Pixel Splitter

This block takes a parallel RGB pixel stream, one 24-bit pixel per clock with data enable, horizontal sync and vertical sync, and spreads it over two output channels, A and B, that run in lockstep. A display link with two channels uses it to halve the pixel rate each channel has to carry. The selected partition fixes which pixels go to which channel. In pass-through mode every pixel goes out on channel A. In interleave mode pixels at odd positions in a line go to A and pixels at even positions go to B. In halves mode the first half of each line goes to A and the second half goes to B.

Each output word packs the three colour components into four 6-bit lane groups. One of two mapping conventions applies, always the same one on both channels, with either 6-bit or 8-bit colour depth. Each channel can invert its data to model a swapped differential pair. All configuration is sampled only when vertical sync rises, so a frame never switches layout part way through.

Top module: `pixel_lane_splitter`

## Requirements
- R1: While reset is asserted, every output is 0 whatever the inputs do.
- R2: In both dual modes (mode 1 interleave, mode 2 halves), aValid and bValid are high on exactly the same cycles. bValid is never high without aValid.
- R3: In mode 0 (and the unused code 3), each pixel with deIn high appears on aData with aValid one clock later. bValid, bData, bDe, bHs and bVs stay 0.
- R4: In mode 1, positions are counted from 1 at the start of each active line. The pixel at odd position 2k-1 and the pixel at even position 2k leave together, on A and on B, one clock after the even pixel arrives.
- R5: In mode 1, when the line length is odd, the last pixel leaves on A one clock after it arrives. B carries an all-zero word on the same cycle, and inversion is applied after the zero is inserted.
- R6: In mode 2, with an even configured line length L, pixel k of the first half and pixel k of the second half leave together on A and on B. This happens one clock after second-half pixel k arrives, and each active line is assumed to be contiguous.
- R7: pixIn is {red, green, blue}, 8 bits each. The output word is {g3, g2, g1, g0} with 6 bits per group, where g0 carries red, g1 green and g2 blue. With jeidaSel=0, g0..g2 carry bits [5:0] of their colour and g3 = {r[7:6], g[7:6], b[7:6]}. With jeidaSel=1, g0..g2 carry bits [7:2] and g3 = {r[1:0], g[1:0], b[1:0]}.
- R8: With sixBitSel=1, g0..g2 carry bits [7:2] of their colour and g3 is 0, whichever mapping is selected.
- R9: When invertA or invertB is set, every bit of each valid word on that channel is inverted. The setting after reset is non-inverted on both channels.
- R10: Mode, mapping, depth, inversion and line length take effect only from a rising edge of vsIn. Changes at any other time have no effect on the outputs.
- R11: aDe, aHs and aVs equal deIn, hsIn and vsIn delayed by one clock, and so do bDe, bHs and bVs in the dual modes. A data word is 0 on any cycle its valid is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pixIn | input | 24 | Input pixel {red, green, blue} |
| deIn | input | 1 | Input data enable |
| hsIn | input | 1 | Input horizontal sync |
| vsIn | input | 1 | Input vertical sync; its rising edge loads the configuration |
| modeSel | input | 2 | 0 pass-through, 1 interleave, 2 halves, 3 treated as 0 |
| jeidaSel | input | 1 | Lane mapping: 0 low-bits-in-groups, 1 high-bits-in-groups |
| sixBitSel | input | 1 | 1 selects 6-bit colour depth |
| invertA | input | 1 | Invert channel A data |
| invertB | input | 1 | Invert channel B data |
| lineLen | input | CW | Active pixels per line (1..MAX_LINE) |
| aValid | output | 1 | Channel A word strobe |
| aData | output | 24 | Channel A lane word |
| aDe | output | 1 | Channel A data enable |
| aHs | output | 1 | Channel A horizontal sync |
| aVs | output | 1 | Channel A vertical sync |
| bValid | output | 1 | Channel B word strobe |
| bData | output | 24 | Channel B lane word |
| bDe | output | 1 | Channel B data enable |
| bHs | output | 1 | Channel B horizontal sync |
| bVs | output | 1 | Channel B vertical sync |

## Verification
The case that is hardest to reach from the ports is the padded end of an odd-length interleaved line while channel B is inverted. It only shows when the line length, the mode and the inversion all arrive together through a vertical-sync rising edge and the line stops on an odd position. The bench programs those values before a frame pulse, sends a five-pixel line, and expects an all-ones word on B beside the last real pixel on A. A second hard case is a configuration change inside a frame: the bench changes every select while vsIn stays low and checks that the previous layout continues until the next frame pulse.

// File: rtl/pls_pkg.sv
package pls_pkg;

  localparam logic [1:0] MODE_SINGLE = 2'd0;
  localparam logic [1:0] MODE_ODDEVEN = 2'd1;
  localparam logic [1:0] MODE_HALVES = 2'd2;

  typedef struct packed {
    logic [1:0] mode;
    logic       jeida;
    logic       sixBit;
    logic       invA;
    logic       invB;
  } cfg_t;

  typedef struct packed {
    logic passThru;
    logic capture;
    logic emitPair;
    logic emitPad;
    logic bufWrite;
    logic bufRead;
  } strobe_t;

  function automatic logic [23:0] laneMap(input logic [23:0] px,
                                          input logic jeida,
                                          input logic sixBit);
    logic [7:0] red, grn, blu;
    logic [5:0] grp0, grp1, grp2, grp3;
    red = px[23:16];
    grn = px[15:8];
    blu = px[7:0];
    if (sixBit || jeida) begin
      grp0 = red[7:2];
      grp1 = grn[7:2];
      grp2 = blu[7:2];
      grp3 = sixBit ? 6'd0 : {red[1:0], grn[1:0], blu[1:0]};
    end else begin
      grp0 = red[5:0];
      grp1 = grn[5:0];
      grp2 = blu[5:0];
      grp3 = {red[7:6], grn[7:6], blu[7:6]};
    end
    return {grp3, grp2, grp1, grp0};
  endfunction

endpackage

// File: rtl/pls_ctrl.sv
module pls_ctrl
  import pls_pkg::*;
#(
  parameter int MAX_LINE = 64,
  parameter int CW = 7,
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          de,
  input  logic          vs,
  input  cfg_t          cfgIn,
  input  logic [CW-1:0] lenIn,
  output cfg_t          cfgOut,
  output strobe_t       stb,
  output logic [AW-1:0] bufIdx
);

  localparam logic [CW-1:0] POS_MAX = CW'(MAX_LINE);

  logic          vsPrev;
  logic          frameStart;
  cfg_t          cfgQ;
  logic [CW-1:0] lenQ;
  logic [CW-1:0] pos;
  logic [CW-1:0] curPos;
  logic [CW-1:0] halfLen;
  logic [CW-1:0] idx;

  // Tracks vs even during reset so the first edge after reset is judged correctly.
  always_ff @(posedge clk) vsPrev <= vs;
  assign frameStart = vs & ~vsPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgQ <= '0;
      lenQ <= POS_MAX;
    end else if (frameStart) begin
      cfgQ <= cfgIn;
      lenQ <= (lenIn > POS_MAX) ? POS_MAX : lenIn;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              pos <= '0;
    else if (!de)           pos <= '0;
    else if (pos < POS_MAX) pos <= pos + CW'(1);
  end

  assign curPos  = pos + CW'(1);
  assign halfLen = lenQ >> 1;

  always_comb begin
    stb = '0;
    idx = '0;
    case (cfgQ.mode)
      MODE_ODDEVEN: begin
        stb.capture  = de & curPos[0];
        stb.emitPad  = de & curPos[0] & (curPos == lenQ);
        stb.emitPair = de & ~curPos[0];
      end
      MODE_HALVES: begin
        if (de && curPos <= halfLen) begin
          stb.bufWrite = 1'b1;
          idx = curPos - CW'(1);
        end else if (de && curPos <= lenQ) begin
          stb.bufRead = 1'b1;
          idx = curPos - halfLen - CW'(1);
        end
      end
      default: stb.passThru = de;
    endcase
  end

  assign bufIdx = idx[AW-1:0];
  assign cfgOut = cfgQ;

endmodule

// File: rtl/pls_path.sv
module pls_path
  import pls_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [23:0]   pix,
  input  logic          de,
  input  logic          hs,
  input  logic          vs,
  input  cfg_t          cfg,
  input  strobe_t       stb,
  input  logic [AW-1:0] bufIdx,
  output logic          aValid,
  output logic [23:0]   aData,
  output logic          aDe,
  output logic          aHs,
  output logic          aVs,
  output logic          bValid,
  output logic [23:0]   bData,
  output logic          bDe,
  output logic          bHs,
  output logic          bVs
);

  logic [23:0] mapped;
  logic [23:0] holdQ;
  logic [23:0] halfMem [DEPTH];
  logic        nextAV, nextBV;
  logic [23:0] nextAW, nextBW;
  logic        dual;

  assign mapped = laneMap(pix, cfg.jeida, cfg.sixBit);
  assign dual   = (cfg.mode == MODE_ODDEVEN) || (cfg.mode == MODE_HALVES);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            holdQ <= '0;
    else if (stb.capture) holdQ <= mapped;
  end

  always_ff @(posedge clk) begin
    if (stb.bufWrite) halfMem[bufIdx] <= mapped;
  end

  always_comb begin
    nextAV = 1'b0;
    nextBV = 1'b0;
    nextAW = '0;
    nextBW = '0;
    if (stb.passThru) begin
      nextAV = 1'b1;
      nextAW = mapped;
    end
    if (stb.emitPair) begin
      nextAV = 1'b1;
      nextBV = 1'b1;
      nextAW = holdQ;
      nextBW = mapped;
    end
    if (stb.emitPad) begin
      nextAV = 1'b1;
      nextBV = 1'b1;
      nextAW = mapped;
    end
    if (stb.bufRead) begin
      nextAV = 1'b1;
      nextBV = 1'b1;
      nextAW = halfMem[bufIdx];
      nextBW = mapped;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      aValid <= 1'b0;
      aData  <= '0;
      aDe    <= 1'b0;
      aHs    <= 1'b0;
      aVs    <= 1'b0;
      bValid <= 1'b0;
      bData  <= '0;
      bDe    <= 1'b0;
      bHs    <= 1'b0;
      bVs    <= 1'b0;
    end else begin
      aValid <= nextAV;
      aData  <= nextAV ? (nextAW ^ {24{cfg.invA}}) : '0;
      aDe    <= de;
      aHs    <= hs;
      aVs    <= vs;
      bValid <= nextBV;
      bData  <= nextBV ? (nextBW ^ {24{cfg.invB}}) : '0;
      bDe    <= de & dual;
      bHs    <= hs & dual;
      bVs    <= vs & dual;
    end
  end

endmodule

// File: rtl/pixel_lane_splitter.sv
module pixel_lane_splitter
  import pls_pkg::*;
#(
  parameter int MAX_LINE = 64,
  localparam int CW = $clog2(MAX_LINE + 1),
  localparam int DEPTH = MAX_LINE / 2,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [23:0]   pixIn,
  input  logic          deIn,
  input  logic          hsIn,
  input  logic          vsIn,
  input  logic [1:0]    modeSel,
  input  logic          jeidaSel,
  input  logic          sixBitSel,
  input  logic          invertA,
  input  logic          invertB,
  input  logic [CW-1:0] lineLen,
  output logic          aValid,
  output logic [23:0]   aData,
  output logic          aDe,
  output logic          aHs,
  output logic          aVs,
  output logic          bValid,
  output logic [23:0]   bData,
  output logic          bDe,
  output logic          bHs,
  output logic          bVs
);

  cfg_t          cfgReq;
  cfg_t          activeCfg;
  strobe_t       stb;
  logic [AW-1:0] bufIdx;

  assign cfgReq = '{mode: modeSel, jeida: jeidaSel, sixBit: sixBitSel,
                    invA: invertA, invB: invertB};

  pls_ctrl #(.MAX_LINE(MAX_LINE), .CW(CW), .AW(AW)) u_ctrl (
    .clk(clk), .rstN(rstN), .de(deIn), .vs(vsIn), .cfgIn(cfgReq),
    .lenIn(lineLen), .cfgOut(activeCfg), .stb(stb), .bufIdx(bufIdx)
  );

  pls_path #(.DEPTH(DEPTH), .AW(AW)) u_path (
    .clk(clk), .rstN(rstN), .pix(pixIn), .de(deIn), .hs(hsIn), .vs(vsIn),
    .cfg(activeCfg), .stb(stb), .bufIdx(bufIdx),
    .aValid(aValid), .aData(aData), .aDe(aDe), .aHs(aHs), .aVs(aVs),
    .bValid(bValid), .bData(bData), .bDe(bDe), .bHs(bHs), .bVs(bVs)
  );

endmodule

// File: rtl/pls_checker.sv
module pls_checker
  import pls_pkg::*;
(
  input logic        clk,
  input logic        rstN,
  input logic        vsIn,
  input logic        aValid,
  input logic [23:0] aData,
  input logic        bValid,
  input logic [23:0] bData,
  input logic        bDe,
  input logic        bHs,
  input logic        bVs,
  input cfg_t        cfgNow
);

  logic dualNow;
  assign dualNow = (cfgNow.mode == MODE_ODDEVEN) || (cfgNow.mode == MODE_HALVES);

  a_r2_b_never_alone: assert property (@(posedge clk) disable iff (!rstN)
    bValid |-> aValid);

  a_r2_lockstep: assert property (@(posedge clk) disable iff (!rstN)
    dualNow |=> (aValid == bValid));

  a_r3_b_idle: assert property (@(posedge clk) disable iff (!rstN)
    !dualNow |=> (!bValid && !bDe && !bHs && !bVs && bData == 24'd0));

  a_r11_a_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !aValid |-> (aData == 24'd0));

  a_r11_b_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !bValid |-> (bData == 24'd0));

  a_r10_cfg_frame_only: assert property (@(posedge clk) disable iff (!rstN)
    !($past(vsIn) && !$past(vsIn, 2)) |-> $stable(cfgNow));

endmodule

bind pixel_lane_splitter pls_checker u_chk (
  .clk(clk), .rstN(rstN), .vsIn(vsIn),
  .aValid(aValid), .aData(aData), .bValid(bValid), .bData(bData),
  .bDe(bDe), .bHs(bHs), .bVs(bVs), .cfgNow(activeCfg)
);

// File: tb/pixel_lane_splitter_bench.sv
`timescale 1ns/1ps
module pixel_lane_splitter_bench;

  localparam int MAX_LINE = 64;
  localparam int CW = $clog2(MAX_LINE + 1);

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [23:0]   pixIn = '0;
  logic          deIn = 1'b0, hsIn = 1'b0, vsIn = 1'b0;
  logic [1:0]    modeSel = '0;
  logic          jeidaSel = 1'b0, sixBitSel = 1'b0, invertA = 1'b0, invertB = 1'b0;
  logic [CW-1:0] lineLen = CW'(8);
  logic          aValid, aDe, aHs, aVs, bValid, bDe, bHs, bVs;
  logic [23:0]   aData, bData;

  pixel_lane_splitter #(.MAX_LINE(MAX_LINE)) u_pixel_lane_splitter (
    .clk(clk), .rstN(rstN), .pixIn(pixIn), .deIn(deIn), .hsIn(hsIn), .vsIn(vsIn),
    .modeSel(modeSel), .jeidaSel(jeidaSel), .sixBitSel(sixBitSel),
    .invertA(invertA), .invertB(invertB), .lineLen(lineLen),
    .aValid(aValid), .aData(aData), .aDe(aDe), .aHs(aHs), .aVs(aVs),
    .bValid(bValid), .bData(bData), .bDe(bDe), .bHs(bHs), .bVs(bVs)
  );

  always #2 clk = ~clk;

  int checks = 0, fails = 0, edgeNo = 0;
  logic [23:0] qa[$], qb[$];
  int ea[$], eb[$];
  int bBusy = 0, aLoud = 0, aHsEdge = -1, bHsEdge = -1;
  logic [23:0] linePix[64];
  int stamp[64];

  always @(posedge clk) begin
    #1;
    edgeNo++;
    if (aValid) begin qa.push_back(aData); ea.push_back(edgeNo); end
    if (bValid) begin qb.push_back(bData); eb.push_back(edgeNo); end
    if (bDe || bHs || bVs || bValid || bData != 0) bBusy++;
    if (!aValid && aData != 0) aLoud++;
    if (aHs && aHsEdge < 0) aHsEdge = edgeNo;
    if (bHs && bHsEdge < 0) bHsEdge = edgeNo;
  end

  function automatic logic [23:0] expWord(logic [23:0] px, bit jeida, bit six);
    logic [7:0] r, g, b;
    r = px[23:16]; g = px[15:8]; b = px[7:0];
    if (six)   return {6'd0, b[7:2], g[7:2], r[7:2]};
    if (jeida) return {r[1:0], g[1:0], b[1:0], b[7:2], g[7:2], r[7:2]};
    return {r[7:6], g[7:6], b[7:6], b[5:0], g[5:0], r[5:0]};
  endfunction

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic clearQ();
    qa.delete(); qb.delete(); ea.delete(); eb.delete();
    bBusy = 0; aLoud = 0; aHsEdge = -1; bHsEdge = -1;
  endtask

  task automatic setupFrame(int mode, bit jeida, bit six, bit ia, bit ib, int len);
    @(negedge clk);
    modeSel = 2'(mode); jeidaSel = jeida; sixBitSel = six;
    invertA = ia; invertB = ib; lineLen = CW'(len);
    vsIn = 1'b1;
    @(negedge clk);
    vsIn = 1'b0;
    repeat (2) @(negedge clk);
    clearQ();
  endtask

  task automatic sendLine(int n, int seed);
    for (int i = 0; i < n; i++)
      linePix[i] = {8'(i * 37 + seed), 8'(i * 91 + seed * 3 + 11), 8'(i * 53 + 200 - seed)};
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      deIn = 1'b1; pixIn = linePix[i]; stamp[i] = edgeNo + 1;
    end
    @(negedge clk);
    deIn = 1'b0; pixIn = '0;
    repeat (3) @(negedge clk);
  endtask

  task automatic testReset();
    deIn = 1'b1; hsIn = 1'b1; pixIn = 24'hFFFFFF; modeSel = 2'd1;
    repeat (2) @(negedge clk);
    chk(!aValid && !bValid, "R1", "valids in reset", {aValid, bValid}, 0);
    chk(aData == 0 && bData == 0, "R1", "data in reset", aData | bData, 0);
    chk(!aDe && !aHs && !aVs && !bDe && !bHs && !bVs, "R1", "syncs in reset",
        {aDe, aHs, aVs, bDe, bHs, bVs}, 0);
    deIn = 1'b0; hsIn = 1'b0; pixIn = '0;
    @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  // Selects are changed without a frame pulse: reset defaults must still hold.
  task automatic testDefaults();
    modeSel = 2'd1; invertA = 1'b1; invertB = 1'b1; jeidaSel = 1'b1;
    clearQ();
    sendLine(4, 7);
    chk(qa.size() == 4, "R10", "words on A with default pass-through", qa.size(), 4);
    chk(qb.size() == 0, "R10", "words on B with default pass-through", qb.size(), 0);
    if (qa.size() == 4)
      for (int k = 0; k < 4; k++)
        chk(qa[k] == expWord(linePix[k], 0, 0), "R9", "default non-inverted word",
            qa[k], expWord(linePix[k], 0, 0));
  endtask

  task automatic testSingle();
    setupFrame(0, 0, 0, 0, 0, 8);
    sendLine(5, 1);
    chk(qa.size() == 5, "R3", "A word count", qa.size(), 5);
    if (qa.size() == 5)
      for (int k = 0; k < 5; k++) begin
        chk(qa[k] == expWord(linePix[k], 0, 0), "R3", "A word", qa[k], expWord(linePix[k], 0, 0));
        chk(ea[k] == stamp[k], "R3", "A latency", ea[k], stamp[k]);
      end
    chk(bBusy == 0, "R3", "B activity cycles", bBusy, 0);
    chk(aLoud == 0, "R11", "A data while not valid", aLoud, 0);
  endtask

  task automatic testSync();
    int s;
    setupFrame(1, 0, 0, 0, 0, 8);
    @(negedge clk);
    hsIn = 1'b1; s = edgeNo + 1;
    @(negedge clk);
    hsIn = 1'b0;
    repeat (2) @(negedge clk);
    chk(aHsEdge == s, "R11", "A hsync delay", aHsEdge, s);
    chk(bHsEdge == s, "R11", "B hsync delay", bHsEdge, s);
  endtask

  task automatic testOddEven();
    setupFrame(1, 0, 0, 0, 0, 6);
    sendLine(6, 2);
    chk(qa.size() == 3 && qb.size() == 3, "R4", "pair count", qa.size() * 16 + qb.size(), 'h33);
    if (qa.size() == 3 && qb.size() == 3)
      for (int k = 0; k < 3; k++) begin
        chk(qa[k] == expWord(linePix[2*k], 0, 0), "R4", "odd pixel on A", qa[k], expWord(linePix[2*k], 0, 0));
        chk(qb[k] == expWord(linePix[2*k+1], 0, 0), "R4", "even pixel on B", qb[k], expWord(linePix[2*k+1], 0, 0));
        chk(ea[k] == stamp[2*k+1], "R4", "pair latency", ea[k], stamp[2*k+1]);
        chk(eb[k] == ea[k], "R2", "A/B lockstep", eb[k], ea[k]);
      end
  endtask

  task automatic testPad();
    setupFrame(1, 0, 0, 0, 0, 5);
    sendLine(5, 3);
    chk(qa.size() == 3 && qb.size() == 3, "R5", "pair count", qa.size() * 16 + qb.size(), 'h33);
    if (qa.size() == 3 && qb.size() == 3) begin
      chk(qa[2] == expWord(linePix[4], 0, 0), "R5", "last pixel on A", qa[2], expWord(linePix[4], 0, 0));
      chk(qb[2] == 0, "R5", "pad word on B", qb[2], 0);
      chk(ea[2] == stamp[4] && eb[2] == stamp[4], "R5", "pad latency", ea[2], stamp[4]);
    end
  endtask

  task automatic testHalves();
    setupFrame(2, 0, 0, 0, 0, 8);
    sendLine(8, 4);
    chk(qa.size() == 4 && qb.size() == 4, "R6", "pair count", qa.size() * 16 + qb.size(), 'h44);
    if (qa.size() == 4 && qb.size() == 4)
      for (int k = 0; k < 4; k++) begin
        chk(qa[k] == expWord(linePix[k], 0, 0), "R6", "left pixel on A", qa[k], expWord(linePix[k], 0, 0));
        chk(qb[k] == expWord(linePix[4+k], 0, 0), "R6", "right pixel on B", qb[k], expWord(linePix[4+k], 0, 0));
        chk(ea[k] == stamp[4+k], "R6", "pair latency", ea[k], stamp[4+k]);
        chk(eb[k] == ea[k], "R2", "A/B lockstep", eb[k], ea[k]);
      end
  endtask

  task automatic sendOne(logic [23:0] px);
    @(negedge clk);
    deIn = 1'b1; pixIn = px;
    @(negedge clk);
    deIn = 1'b0; pixIn = '0;
    repeat (2) @(negedge clk);
  endtask

  task automatic testMapping();
    setupFrame(0, 0, 0, 0, 0, 8);
    sendOne(24'hC00000);
    chk(qa.size() == 1 && qa[0] == 24'hC00000, "R7", "low-bits mapping of red top bits", qa[0], 24'hC00000);
    setupFrame(0, 1, 0, 0, 0, 8);
    sendOne(24'hC00000);
    chk(qa.size() == 1 && qa[0] == 24'h000030, "R7", "high-bits mapping of red top bits", qa[0], 24'h000030);
    clearQ();
    sendLine(3, 9);
    if (qa.size() == 3)
      for (int k = 0; k < 3; k++)
        chk(qa[k] == expWord(linePix[k], 1, 0), "R7", "high-bits mapping word", qa[k], expWord(linePix[k], 1, 0));
    else
      chk(0, "R7", "word count", qa.size(), 3);
  endtask

  task automatic testSixBit();
    setupFrame(0, 0, 1, 0, 0, 8);
    sendOne(24'hFFFFFF);
    chk(qa.size() == 1 && qa[0] == 24'h03FFFF, "R8", "6-bit group3 zero", qa[0], 24'h03FFFF);
    setupFrame(0, 1, 1, 0, 0, 8);
    sendOne(24'h81C3E7);
    chk(qa.size() == 1 && qa[0] == expWord(24'h81C3E7, 0, 1), "R8", "6-bit with high-bits mapping",
        qa[0], expWord(24'h81C3E7, 0, 1));
  endtask

  task automatic testInvert();
    setupFrame(1, 0, 0, 1, 0, 4);
    sendLine(4, 5);
    if (qa.size() == 2 && qb.size() == 2) begin
      chk(qa[0] == ~expWord(linePix[0], 0, 0), "R9", "A inverted", qa[0], ~expWord(linePix[0], 0, 0));
      chk(qb[1] == expWord(linePix[3], 0, 0), "R9", "B not inverted", qb[1], expWord(linePix[3], 0, 0));
    end else
      chk(0, "R9", "pair count", qa.size(), 2);
    setupFrame(1, 0, 0, 0, 1, 5);
    sendLine(5, 6);
    chk(qb.size() == 3 && qb[2] == 24'hFFFFFF, "R5", "inverted pad on B", qb[2], 24'hFFFFFF);
    chk(qa.size() == 3 && qa[2] == expWord(linePix[4], 0, 0), "R9", "A unaffected by B inversion",
        qa[2], expWord(linePix[4], 0, 0));
  endtask

  task automatic testMidFrame();
    setupFrame(1, 0, 0, 0, 0, 4);
    modeSel = 2'd0; invertA = 1'b1; lineLen = CW'(2);
    sendLine(4, 8);
    chk(qb.size() == 2, "R10", "interleave kept mid-frame", qb.size(), 2);
    chk(qa.size() == 2 && qa[0] == expWord(linePix[0], 0, 0), "R10", "inversion ignored mid-frame",
        qa[0], expWord(linePix[0], 0, 0));
    setupFrame(0, 0, 0, 0, 0, 4);
    sendLine(4, 10);
    chk(qa.size() == 4 && qb.size() == 0, "R10", "new mode after frame pulse", qa.size() * 16 + qb.size(), 'h40);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not complete, got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    testReset();
    testDefaults();
    testSingle();
    testSync();
    testOddEven();
    testPad();
    testHalves();
    testMapping();
    testSixBit();
    testInvert();
    testMidFrame();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule